// File: doc/BRIEF.md
# Processor Interrupt Request Front End

This block sits between the raw interrupt pins of a small processor core and its sequencer. It brings three asynchronous inputs into the core clock domain: a maskable level-sensitive request, a non-maskable edge-sensitive request and a test level. At each instruction boundary it decides whether the core should enter an interrupt. If it does, the block reports the vector type to use and whether an acknowledge bus sequence must fetch that type from the interrupting device.

The core marks the last clock of every instruction with a one-cycle `instr_end` strobe and supplies the current interrupt-enable flag. When the block takes an interrupt it pulses `take_irq` and enters a servicing state. It holds `vec_type` and `need_ack_cycle` until the core returns `ack_done`. A rising edge on the non-maskable pin is caught and held pending, so a short pulse is not lost. The maskable pin is looked at only during the boundary clock. The test level is resynchronized on every clock and goes straight out to the core.

Top module: `irq_front_end`

## Requirements
- R1: After a synchronous active-low reset, `take_irq`, `vec_type`, `need_ack_cycle` and `test_sync` are all 0, and no non-maskable request is pending.
- R2: A low-to-high transition on `nmi_raw` that lasts at least two clocks is kept pending even if the pin returns low before the boundary. At the next idle boundary it is taken with `vec_type` = 2 and `need_ack_cycle` = 0.
- R3: A pending non-maskable request is taken whatever the value of `int_enable`.
- R4: The maskable request is taken at an idle boundary only if its synchronized level is high during that `instr_end` clock and `int_enable` is 1. It is then reported with `vec_type` = 0 and `need_ack_cycle` = 1. A level that drops before the boundary is not taken.
- R5: With `int_enable` = 0, a high maskable level produces no `take_irq`.
- R6: When both requests are ready at the same boundary, the non-maskable one is taken. The maskable one is considered again at the next idle boundary.
- R7: Taking the non-maskable interrupt clears its pending state. A new rising edge that arrives while servicing becomes a fresh pending request.
- R8: `test_sync` equals the value `test_raw` had two rising clock edges earlier. It is unchanged after one edge.
- R9: `take_irq` is high for exactly one cycle, in the clock after the `instr_end` cycle. From then until `ack_done` is seen, boundaries are ignored and no new interrupt is taken.
- R10: A non-maskable pin held high triggers only one interrupt. Further boundaries produce nothing until the pin goes low and high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_raw | input | 1 | Asynchronous maskable request level |
| nmi_raw | input | 1 | Asynchronous non-maskable request, rising-edge sensitive |
| test_raw | input | 1 | Asynchronous test level |
| instr_end | input | 1 | High during the last clock of an instruction |
| int_enable | input | 1 | Interrupt-enable flag of the core |
| ack_done | input | 1 | Core finished the interrupt entry; leave servicing state |
| take_irq | output | 1 | One-cycle pulse: enter interrupt |
| vec_type | output | VEC_W | Vector type; 2 for non-maskable, 0 for maskable (fetched by acknowledge) |
| need_ack_cycle | output | 1 | An acknowledge bus sequence must fetch the vector type |
| test_sync | output | 1 | Synchronized test level |

## Verification
The bench targets a non-maskable pulse that ends long before the boundary. A design that sampled the level instead of latching the edge would drop it. It also raises a maskable level and removes it before the boundary; a design that latched the maskable request would then take a stray interrupt. Further cases cover both requests arriving together, a held-high non-maskable pin, and a second edge during servicing. Getting these wrong would show up as a wrong vector, a lost maskable request, a repeated interrupt, or a lost second request. Boundaries are also driven while servicing, and a design that failed to block them would pulse `take_irq` twice.

// File: rtl/irq_fe_pkg.sv
// Package: shared types and constants of the interrupt request front end.
// Assumes: the synchronized input bundle is ordered maskable, non-maskable, test.
package irq_fe_pkg;

    // Positions of the three inputs inside the synchronizer bundle
    localparam int unsigned IN_COUNT = 3;
    localparam int unsigned IDX_MASK = 0;
    localparam int unsigned IDX_NMI  = 1;
    localparam int unsigned IDX_TEST = 2;

    // Servicing state of the decision logic
    typedef enum logic {
        SVC_IDLE = 1'b0,
        SVC_BUSY = 1'b1
    } svc_state_e;

endpackage

// File: rtl/irq_sync.sv
// Module: multi-stage flip-flop synchronizer for a bundle of independent bits.
// Assumes: each bit is a quasi-static level; no bus coherence across bits is needed.
// Every stage is reset low by the synchronous active-low reset.
module irq_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= din;
                end
            end else begin : g_next
                // Later stages: let metastability settle
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[LAST];

endmodule

// File: rtl/irq_edge_latch.sv
// Module: rising-edge detector with a pending latch for the non-maskable request.
// Assumes: 'level' is already synchronized. 'clear' is a one-cycle strobe from the
// decision logic. A rise in the clearing cycle survives, so a new edge is never lost.
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic clear,
    output logic pending
);

    logic prev_q;
    logic pend_q;
    logic rise;

    // Compare the synchronized level with its value one cycle earlier
    assign rise = level & ~prev_q;

    // Remember the previous synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Set on a rise, hold until cleared; a rise beats the clear
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (rise)  pend_q <= 1'b1;
        else if (clear) pend_q <= 1'b0;
    end

    assign pending = pend_q;

    // R7: a detected rise always leaves a pending request behind
    a_r7_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pending);

    // R10: a steady-high level cannot create a new pending request
    a_r10_no_set_on_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && prev_q) |=> !pending);

endmodule

// File: rtl/irq_arbiter.sv
// Module: boundary decision and servicing state for the interrupt front end.
// Assumes: 'instr_end' marks the last clock of an instruction; inputs are synchronized.
// The non-maskable request has priority; only one interrupt is serviced at a time.
module irq_arbiter
    import irq_fe_pkg::*;
#(
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned NMI_VEC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_end,
    input  logic             int_enable,
    input  logic             mask_lvl,
    input  logic             nmi_pend,
    input  logic             ack_done,
    output logic             nmi_clear,
    output logic             take_irq,
    output logic [VEC_W-1:0] vec_type,
    output logic             need_ack_cycle
);

    localparam logic [VEC_W-1:0] VEC_NMI  = VEC_W'(NMI_VEC);
    localparam logic [VEC_W-1:0] VEC_NONE = '0;

    svc_state_e       state_q;
    logic             take_q;
    logic [VEC_W-1:0] vec_q;
    logic             ack_q;
    logic             at_boundary;
    logic             pick_nmi;
    logic             pick_mask;

    // Decide at an idle boundary; non-maskable first, maskable only when enabled
    always_comb begin
        at_boundary = (state_q == SVC_IDLE) && instr_end;
        pick_nmi    = at_boundary && nmi_pend;
        pick_mask   = at_boundary && !nmi_pend && int_enable && mask_lvl;
    end

    assign nmi_clear = pick_nmi;

    // One-cycle take pulse in the clock after the decision
    always_ff @(posedge clk) begin
        if (!rst_n) take_q <= 1'b0;
        else        take_q <= pick_nmi | pick_mask;
    end

    // Servicing state with held vector type and acknowledge flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
            vec_q   <= VEC_NONE;
            ack_q   <= 1'b0;
        end else if (pick_nmi) begin
            state_q <= SVC_BUSY;
            vec_q   <= VEC_NMI;
            ack_q   <= 1'b0;
        end else if (pick_mask) begin
            state_q <= SVC_BUSY;
            vec_q   <= VEC_NONE;
            ack_q   <= 1'b1;
        end else if (state_q == SVC_BUSY && ack_done) begin
            state_q <= SVC_IDLE;
            vec_q   <= VEC_NONE;
            ack_q   <= 1'b0;
        end
    end

    assign take_irq       = take_q;
    assign vec_type       = vec_q;
    assign need_ack_cycle = ack_q;

    // R9: the take strobe never lasts two cycles
    a_r9_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq);

    // R9: nothing is taken while an interrupt is being serviced
    a_r9_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SVC_BUSY && !ack_done) |=> !take_irq);

    // R6: a pending non-maskable request at an idle boundary wins, without acknowledge
    a_r6_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SVC_IDLE && instr_end && nmi_pend) |=> (take_irq && !need_ack_cycle));

    // R2: a take without acknowledge carries the non-maskable vector type
    a_r2_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !need_ack_cycle) |-> vec_type == VEC_NMI);

    // R5: with interrupts disabled and nothing non-maskable, a boundary is quiet
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end && !int_enable && !nmi_pend) |=> !take_irq);

endmodule

// File: rtl/irq_front_end.sv
// Module: interrupt request front end (top).
// Synchronizes the maskable, non-maskable and test inputs and latches non-maskable
// edges. At each instruction boundary it decides whether to enter an interrupt.
// Assumes: raw inputs are asynchronous; synchronous active-low reset.
module irq_front_end
    import irq_fe_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned VEC_W       = 8,
    parameter int unsigned NMI_VEC     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_raw,
    input  logic             nmi_raw,
    input  logic             test_raw,
    input  logic             instr_end,
    input  logic             int_enable,
    input  logic             ack_done,
    output logic             take_irq,
    output logic [VEC_W-1:0] vec_type,
    output logic             need_ack_cycle,
    output logic             test_sync
);

    logic [IN_COUNT-1:0] raw_bus;
    logic [IN_COUNT-1:0] sync_bus;
    logic                nmi_pend;
    logic                nmi_clear;

    // Gather the asynchronous inputs into one bundle
    always_comb begin
        raw_bus           = '0;
        raw_bus[IDX_MASK] = mask_raw;
        raw_bus[IDX_NMI]  = nmi_raw;
        raw_bus[IDX_TEST] = test_raw;
    end

    irq_sync #(
        .WIDTH  (IN_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_bus),
        .dout  (sync_bus)
    );

    irq_edge_latch u_nmi_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (sync_bus[IDX_NMI]),
        .clear   (nmi_clear),
        .pending (nmi_pend)
    );

    irq_arbiter #(
        .VEC_W   (VEC_W),
        .NMI_VEC (NMI_VEC)
    ) u_arb (
        .clk            (clk),
        .rst_n          (rst_n),
        .instr_end      (instr_end),
        .int_enable     (int_enable),
        .mask_lvl       (sync_bus[IDX_MASK]),
        .nmi_pend       (nmi_pend),
        .ack_done       (ack_done),
        .nmi_clear      (nmi_clear),
        .take_irq       (take_irq),
        .vec_type       (vec_type),
        .need_ack_cycle (need_ack_cycle)
    );

    assign test_sync = sync_bus[IDX_TEST];

    // R4: a maskable take always asks for the acknowledge sequence with type 0 held
    a_r4_mask_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && need_ack_cycle) |-> vec_type == '0);

endmodule

// File: tb/irq_front_end_tb.sv
// Bench: scoreboard of expected takes; a monitor pops them as take_irq pulses.
module irq_front_end_tb;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned VEC_W      = 8;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             ack;
        logic [7:0]       req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mask_raw = 1'b0;
    logic             nmi_raw = 1'b0;
    logic             test_raw = 1'b0;
    logic             instr_end = 1'b0;
    logic             int_enable = 1'b0;
    logic             ack_done = 1'b0;
    logic             take_irq;
    logic [VEC_W-1:0] vec_type;
    logic             need_ack_cycle;
    logic             test_sync;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_front_end #(.VEC_W(VEC_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mask_raw       (mask_raw),
        .nmi_raw        (nmi_raw),
        .test_raw       (test_raw),
        .instr_end      (instr_end),
        .int_enable     (int_enable),
        .ack_done       (ack_done),
        .take_irq       (take_irq),
        .vec_type       (vec_type),
        .need_ack_cycle (need_ack_cycle),
        .test_sync      (test_sync)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One-cycle boundary strobe; push the expected take (if any) first
    task automatic boundary(input bit expect_take, input int vec, input bit ack, input int req);
        exp_t e;
        if (expect_take) begin
            e.vec = VEC_W'(vec);
            e.ack = ack;
            e.req = 8'(req);
            exp_q.push_back(e);
        end
        instr_end = 1'b1;
        @(negedge clk);
        instr_end = 1'b0;
        if (!expect_take)
            check(take_irq == 1'b0, $sformatf("R%0d no take", req), take_irq, 0);
        @(negedge clk);
        check(take_irq == 1'b0, "R9 single-cycle take", take_irq, 0);
    endtask

    task automatic ack_pulse();
        ack_done = 1'b1;
        @(negedge clk);
        ack_done = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pop and compare on every take pulse
    always @(negedge clk) begin
        if (rst_n && take_irq) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected take", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(vec_type == e.vec, $sformatf("R%0d vec_type", e.req), vec_type, e.vec);
                check(need_ack_cycle == e.ack, $sformatf("R%0d need_ack_cycle", e.req),
                      need_ack_cycle, e.ack);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        check(1'b0, "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(take_irq == 0, "R1 take_irq", take_irq, 0);
        check(vec_type == 0, "R1 vec_type", vec_type, 0);
        check(need_ack_cycle == 0, "R1 need_ack_cycle", need_ack_cycle, 0);
        check(test_sync == 0, "R1 test_sync", test_sync, 0);
        boundary(1'b0, 0, 1'b0, 1);   // r1_: nothing pending after reset

        // R8: test level follows after two edges
        test_raw = 1'b1;
        @(negedge clk);
        check(test_sync == 0, "R8 after one edge", test_sync, 0);
        @(negedge clk);
        check(test_sync == 1, "R8 after two edges", test_sync, 1);
        test_raw = 1'b0;
        idle(2);
        check(test_sync == 0, "R8 falls", test_sync, 0);

        // R2 + R3: short NMI pulse, interrupts disabled, taken later with type 2
        int_enable = 1'b0;
        nmi_raw = 1'b1;
        idle(2);
        nmi_raw = 1'b0;
        idle(6);
        boundary(1'b1, 2, 1'b0, 2);
        check(vec_type == 2, "R3 type held while servicing", vec_type, 2);
        ack_pulse();
        // R7: pending cleared after take
        boundary(1'b0, 0, 1'b0, 7);

        // R4: maskable level high at boundary, enabled
        int_enable = 1'b1;
        mask_raw = 1'b1;
        idle(4);
        boundary(1'b1, 0, 1'b1, 4);
        check(need_ack_cycle == 1, "R4 ack flag held", need_ack_cycle, 1);
        // R9: boundary while busy is ignored
        boundary(1'b0, 0, 1'b0, 9);
        ack_pulse();
        check(need_ack_cycle == 0, "R9 released by ack", need_ack_cycle, 0);
        // R4: level dropped before boundary
        mask_raw = 1'b0;
        idle(4);
        boundary(1'b0, 0, 1'b0, 4);

        // R5: disabled maskable request ignored
        int_enable = 1'b0;
        mask_raw = 1'b1;
        idle(4);
        boundary(1'b0, 0, 1'b0, 5);

        // R6: both ready; NMI first, maskable next boundary
        int_enable = 1'b1;
        nmi_raw = 1'b1;
        idle(2);
        nmi_raw = 1'b0;
        idle(4);
        boundary(1'b1, 2, 1'b0, 6);
        ack_pulse();
        boundary(1'b1, 0, 1'b1, 6);
        ack_pulse();
        mask_raw = 1'b0;
        idle(4);

        // R7: new edge during servicing kept as fresh request
        nmi_raw = 1'b1;
        idle(4);
        boundary(1'b1, 2, 1'b0, 7);
        nmi_raw = 1'b0;
        idle(3);
        nmi_raw = 1'b1;
        idle(5);
        ack_pulse();
        boundary(1'b1, 2, 1'b0, 7);
        ack_pulse();

        // R10: pin still held high: no further take
        boundary(1'b0, 0, 1'b0, 10);
        idle(3);
        boundary(1'b0, 0, 1'b0, 10);
        nmi_raw = 1'b0;
        idle(4);

        idle(2);
        check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule